// File: doc/BRIEF.md
# Press-Triggered Keypad Matrix Scanner

This block reads a twelve-key matrix of four rows and three columns. The keys are the ten digits, a confirm key and a set key. While nothing is pressed, the block drives every row low and stays still. A column going low wakes it. The press must then stay present for a debounce interval. After that the block walks one low row at a time across the matrix until the pressed key's column answers. It decodes the row and column into a 4-bit key code, reports the press once, and keeps only that key's row low until the key is released. Scanning stops on release, and a new press can be taken only after the columns have read idle for a full debounce interval.

The set key is timed while it is held. If it is held for `LONG_CYC` cycles, the block reports a long press at that moment, while the key is still down. If it is released earlier, the block reports a short press when the release has been debounced. Digit and confirm keys are reported as soon as they are decoded. Each report is a one-cycle `key_valid_o` pulse. The 4-bit code and, for the set key, one of the two classification flags come with that pulse.

Top module: `keypad_scanner`

## Requirements
- R1: After reset and whenever no press is being handled, `row_o` is 4'b0000 and `key_valid_o`, `set_long_o` and `set_short_o` are 0.
- R2: During a scan, exactly one row is driven low. The rows are visited in the order 4'b0111, 4'b1011, 4'b1101, 4'b1110, each for `SCAN_DWELL` cycles. `row_o[3]` selects the top row.
- R3: A press whose columns stay low for fewer than `DEB_CYC` consecutive synchronized cycles produces no report.
- R4: Layout and digit codes. The top row holds keys 1, 2, 3; the second row 4, 5, 6; the third row 7, 8, 9. The bottom row holds set, 0, confirm. The left column reads on `col_i[2]` and the right column on `col_i[0]`. A digit key reports its own value as the code.
- R5: The confirm key reports code 4'd10 and the set key reports code 4'd11.
- R6: Every accepted press produces exactly one `key_valid_o` pulse, one cycle wide, however long the key is held.
- R7: A set key held for at least `LONG_CYC` cycles after it is decoded produces its single pulse together with `set_long_o`, while still held. It produces no short flag on release.
- R8: A set key released before `LONG_CYC` cycles produces its single pulse together with `set_short_o`, once the release has been debounced.
- R9: `set_long_o` and `set_short_o` are never high together. Either one is high only together with `key_valid_o` and code 4'd11.
- R10: Column-high spells shorter than `DEB_CYC` cycles while a key is held do not end the press and cause no further pulse. After a full release, a later press is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_i | input | 3 | Column inputs, low when a key on a low row is pressed; bit 2 is the left column |
| row_o | output | 4 | Active-low row drive; bit 3 is the top row |
| key_valid_o | output | 1 | One-cycle pulse per accepted press |
| key_code_o | output | 4 | Code of the last reported key (0-9 digits, 10 confirm, 11 set) |
| set_long_o | output | 1 | With the pulse: set key held for the long interval |
| set_short_o | output | 1 | With the pulse: set key released before the long interval |

## Verification
The bench builds the scanner with `DEB_CYC` = 4, `SCAN_DWELL` = 4 and `LONG_CYC` = 200. At these values a full scan of all four rows takes only a few tens of cycles. Holds of a few dozen cycles then stand for short presses, and holds of a few hundred cycles reach the long-press threshold. With these values one run can cover every key of the matrix, both set-key classifications, glitches shorter than the debounce, and release bounce, all well inside the cycle limit.

// File: rtl/keypad_pkg.sv
// Package: shared constants and the controller state type for the keypad
// scanner. Assumes a 4x3 matrix with active-low rows and columns.
package keypad_pkg;
    localparam int unsigned ROWS = 4;
    localparam int unsigned COLS = 3;
    localparam int unsigned RIW  = $clog2(ROWS);
    localparam logic [3:0] CODE_CONFIRM = 4'd10;
    localparam logic [3:0] CODE_SET     = 4'd11;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SCAN   = 2'd2,
        ST_HOLD   = 2'd3
    } scan_state_e;
endpackage

// File: rtl/keypad_sync.sv
// Two-flop synchronizer for the column inputs. Its reset value is all ones
// (idle columns), so the controller never sees a false press after reset.
module keypad_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages to bring the asynchronous columns into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            q_o    <= '1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/keypad_decode.sv
// Combinational key decoder. It maps the row under scan and the synchronized
// columns to a key code. When two columns are low, the leftmost one wins.
// Layout: rows 0..2 hold digits 1..9 from left to right; row 3 holds set, 0,
// confirm.
module keypad_decode
    import keypad_pkg::*;
(
    input  logic [RIW-1:0]  row_idx_i,
    input  logic [COLS-1:0] col_n_i,
    output logic            hit_o,
    output logic [3:0]      code_o
);
    logic [1:0] col_idx;

    // Leftmost low column gives the column index.
    always_comb begin
        hit_o   = 1'b1;
        col_idx = 2'd0;
        if (!col_n_i[2])      col_idx = 2'd0;
        else if (!col_n_i[1]) col_idx = 2'd1;
        else if (!col_n_i[0]) col_idx = 2'd2;
        else                  hit_o   = 1'b0;
    end

    // Row and column together give the key code.
    always_comb begin
        if (row_idx_i == RIW'(ROWS - 1)) begin
            case (col_idx)
                2'd0:    code_o = CODE_SET;
                2'd1:    code_o = 4'd0;
                default: code_o = CODE_CONFIRM;
            endcase
        end else begin
            code_o = 4'(row_idx_i) * 4'd3 + 4'(col_idx) + 4'd1;
        end
    end
endmodule

// File: rtl/keypad_ctrl.sv
// Scan controller. States: idle (all rows low), settle (debounce the wake-up),
// scan (one low row at a time), hold (keep the found row low, time the set
// key, debounce the release). Assumes SCAN_DWELL >= 3 so that the
// two-cycle synchronizer latency has passed before each row is sampled.
module keypad_ctrl
    import keypad_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 20000,
    parameter int unsigned SCAN_DWELL = 4,
    parameter int unsigned LONG_CYC   = 3000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_s_i,
    input  logic            dec_hit_i,
    input  logic [3:0]      dec_code_i,
    output logic [RIW-1:0]  row_idx_o,
    output logic [ROWS-1:0] row_o,
    output logic            key_valid_o,
    output logic [3:0]      key_code_o,
    output logic            set_long_o,
    output logic            set_short_o
);
    localparam int unsigned CNT_MAX = (DEB_CYC > SCAN_DWELL) ? DEB_CYC : SCAN_DWELL;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam int unsigned HW      = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] DEB_LAST   = CW'(DEB_CYC - 1);
    localparam logic [CW-1:0] DWELL_LAST = CW'(SCAN_DWELL - 1);
    localparam logic [HW-1:0] LONG_LAST  = HW'(LONG_CYC - 1);

    scan_state_e    state_q;
    logic [CW-1:0]  cnt_q;
    logic [HW-1:0]  hold_q;
    logic [RIW-1:0] row_q;
    logic           is_set_q;
    logic           long_done_q;
    logic           any_low;
    logic           long_hit;

    assign any_low   = ~&col_s_i;
    assign long_hit  = is_set_q && !long_done_q && (hold_q == LONG_LAST);
    assign row_idx_o = row_q;

    // Row drive: all low when idle or settling, otherwise the selected row only.
    always_comb begin
        if (state_q == ST_SCAN || state_q == ST_HOLD)
            row_o = ~(4'b1000 >> row_q);
        else
            row_o = '0;
    end

    // Main state machine with the debounce, dwell and hold counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            hold_q      <= '0;
            row_q       <= '0;
            is_set_q    <= 1'b0;
            long_done_q <= 1'b0;
            key_valid_o <= 1'b0;
            key_code_o  <= '0;
            set_long_o  <= 1'b0;
            set_short_o <= 1'b0;
        end else begin
            key_valid_o <= 1'b0;
            set_long_o  <= 1'b0;
            set_short_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (any_low) state_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (!any_low) begin
                        state_q <= ST_IDLE;
                    end else if (cnt_q == DEB_LAST) begin
                        state_q <= ST_SCAN;
                        row_q   <= '0;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (cnt_q != DWELL_LAST) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (dec_hit_i) begin
                        state_q     <= ST_HOLD;
                        cnt_q       <= '0;
                        hold_q      <= '0;
                        long_done_q <= 1'b0;
                        key_code_o  <= dec_code_i;
                        is_set_q    <= (dec_code_i == CODE_SET);
                        key_valid_o <= (dec_code_i != CODE_SET);
                    end else if (row_q == RIW'(ROWS - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        row_q <= row_q + 1'b1;
                        cnt_q <= '0;
                    end
                end
                ST_HOLD: begin
                    if (!long_done_q) hold_q <= hold_q + 1'b1;
                    if (long_hit) begin
                        long_done_q <= 1'b1;
                        key_valid_o <= 1'b1;
                        set_long_o  <= 1'b1;
                    end
                    if (any_low) begin
                        cnt_q <= '0;
                    end else if (cnt_q == DEB_LAST) begin
                        state_q <= ST_IDLE;
                        if (is_set_q && !long_done_q && !long_hit) begin
                            key_valid_o <= 1'b1;
                            set_short_o <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: rows are all low whenever the controller rests in idle.
    p_idle_rows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (row_o == 4'b0000));

    // R2: exactly one low row while scanning.
    p_scan_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ($countones(row_o) == 3));

    // R2: the row index only steps forward by one during a scan.
    p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN && !$stable(row_q))
            |-> (row_q == $past(row_q) + 1'b1));

    // R6: a report is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    // R9: classification flags are exclusive and belong to a set-key pulse.
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_long_o && set_short_o));

    p_flag_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_long_o || set_short_o) |-> (key_valid_o && key_code_o == CODE_SET));

    // R7: after a long report the same press yields no short flag.
    p_no_short_after_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        long_done_q |-> !set_short_o);
endmodule

// File: rtl/keypad_scanner.sv
// Top of the press-triggered keypad scanner. It ties together the column
// synchronizer, the key decoder and the scan controller. It assumes external
// pull-ups on the columns and a free-running clock.
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 20000,
    parameter int unsigned SCAN_DWELL = 4,
    parameter int unsigned LONG_CYC   = 3000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] col_i,
    output logic [3:0] row_o,
    output logic       key_valid_o,
    output logic [3:0] key_code_o,
    output logic       set_long_o,
    output logic       set_short_o
);
    logic [COLS-1:0] col_s;
    logic [RIW-1:0]  row_idx;
    logic            dec_hit;
    logic [3:0]      dec_code;

    keypad_sync #(.WIDTH(COLS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (col_i),
        .q_o   (col_s)
    );

    keypad_decode u_decode (
        .row_idx_i (row_idx),
        .col_n_i   (col_s),
        .hit_o     (dec_hit),
        .code_o    (dec_code)
    );

    keypad_ctrl #(
        .DEB_CYC    (DEB_CYC),
        .SCAN_DWELL (SCAN_DWELL),
        .LONG_CYC   (LONG_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_s_i     (col_s),
        .dec_hit_i   (dec_hit),
        .dec_code_i  (dec_code),
        .row_idx_o   (row_idx),
        .row_o       (row_o),
        .key_valid_o (key_valid_o),
        .key_code_o  (key_code_o),
        .set_long_o  (set_long_o),
        .set_short_o (set_short_o)
    );

    // R5/R4: a reported code is always one of the twelve key codes.
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> (key_code_o <= 4'd11));
endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
    localparam int DEB  = 4;
    localparam int DWL  = 4;
    localparam int LNG  = 200;
    localparam int NV   = 14;

    // Stimulus table: key (10 confirm, 11 set), hold cycles, expected code/long/short.
    localparam int VKEY  [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 0, 10, 11, 11, 9};
    localparam int VHOLD [NV] = '{50,50,50,50,50,50,50,50,50,50,50, 50, 300, 260};
    localparam int VCODE [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 0, 10, 11, 11, 9};
    localparam int VLONG [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int VSHRT [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] col;
    logic [3:0] row_o;
    logic       key_valid_o;
    logic [3:0] key_code_o;
    logic       set_long_o;
    logic       set_short_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  pressed = 1'b0;
    int  cur_key = 0;

    int  npulse = 0, nlong = 0, nshort = 0;
    int  last_code = -1;
    logic [3:0] rowlog [8];
    int  nrow = 0;
    logic [3:0] prev_row = 4'b0000;
    bit  logging = 1'b0;

    always #5 clk = ~clk;

    keypad_scanner #(.DEB_CYC(DEB), .SCAN_DWELL(DWL), .LONG_CYC(LNG)) u_keypad_scanner (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_i       (col),
        .row_o       (row_o),
        .key_valid_o (key_valid_o),
        .key_code_o  (key_code_o),
        .set_long_o  (set_long_o),
        .set_short_o (set_short_o)
    );

    // Matrix model: key position from the layout in R4.
    function automatic int key_row(input int k);
        if (k >= 1 && k <= 9) return (k - 1) / 3;
        return 3;
    endfunction
    function automatic int key_col(input int k);
        if (k >= 1 && k <= 9) return (k - 1) % 3;
        if (k == 0)  return 1;
        if (k == 10) return 2;
        return 0;
    endfunction

    always_comb begin
        col = 3'b111;
        if (pressed && row_o[3 - key_row(cur_key)] == 1'b0)
            col[2 - key_col(cur_key)] = 1'b0;
    end

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && key_valid_o) begin
            npulse++;
            last_code = int'(key_code_o);
            if (set_long_o)  nlong++;
            if (set_short_o) nshort++;
        end
        if (logging && row_o != prev_row && nrow < 8) begin
            rowlog[nrow] = row_o;
            nrow++;
        end
        prev_row = row_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        npulse = 0; nlong = 0; nshort = 0; last_code = -1;
    endtask

    task automatic press(input int k, input int hold);
        cur_key = k;
        pressed = 1'b1;
        cyc(hold);
        pressed = 1'b0;
        cyc(40);
    endtask

    initial begin
        cyc(3);
        // R1: reset state.
        check(row_o == 4'b0000, "R1 rows in reset", int'(row_o), 0);
        check(!key_valid_o && !set_long_o && !set_short_o, "R1 outputs in reset",
              int'({key_valid_o, set_long_o, set_short_o}), 0);
        rst_n = 1'b1;
        cyc(5);
        check(row_o == 4'b0000, "R1 idle rows", int'(row_o), 0);

        // Table walk: R4, R5, R6, R7, R8.
        for (int i = 0; i < NV; i++) begin
            clear_mon();
            press(VKEY[i], VHOLD[i]);
            check(npulse == 1, "R6 one pulse per press", npulse, 1);
            check(last_code == VCODE[i], (VKEY[i] >= 10) ? "R5 code" : "R4 code",
                  last_code, VCODE[i]);
            check(nlong == VLONG[i], "R7 long flag", nlong, VLONG[i]);
            check(nshort == VSHRT[i], "R8 short flag", nshort, VSHRT[i]);
            check(row_o == 4'b0000, "R1 rows after release", int'(row_o), 0);
        end

        // R3: a glitch shorter than the debounce is ignored.
        clear_mon();
        press(5, 2);
        check(npulse == 0, "R3 short glitch ignored", npulse, 0);
        check(row_o == 4'b0000, "R3 rows stay idle", int'(row_o), 0);

        // R2: scan order while the bottom-row key 0 is pressed.
        clear_mon();
        nrow = 0;
        logging = 1'b1;
        press(0, 60);
        logging = 1'b0;
        check(nrow >= 5, "R2 row changes seen", nrow, 5);
        check(rowlog[0] == 4'b0111, "R2 first row", int'(rowlog[0]), 7);
        check(rowlog[1] == 4'b1011, "R2 second row", int'(rowlog[1]), 11);
        check(rowlog[2] == 4'b1101, "R2 third row", int'(rowlog[2]), 13);
        check(rowlog[3] == 4'b1110, "R2 fourth row", int'(rowlog[3]), 14);
        check(rowlog[4] == 4'b0000, "R2 back to idle", int'(rowlog[4]), 0);

        // R10: release bounce shorter than the debounce gives no second pulse.
        clear_mon();
        cur_key = 8;
        pressed = 1'b1;
        cyc(40);
        pressed = 1'b0;
        cyc(2);
        pressed = 1'b1;
        cyc(30);
        pressed = 1'b0;
        cyc(1);
        pressed = 1'b1;
        cyc(20);
        pressed = 1'b0;
        cyc(40);
        check(npulse == 1, "R10 bounce single pulse", npulse, 1);
        check(last_code == 8, "R10 bounce code", last_code, 8);

        // R10: a later press after full release is accepted again.
        clear_mon();
        press(3, 50);
        check(npulse == 1, "R10 press after release", npulse, 1);
        check(last_code == 3, "R10 code after release", last_code, 3);

        // R9: a set key held past the threshold and then released reports only long.
        clear_mon();
        press(11, 240);
        check(nlong == 1 && nshort == 0, "R9 exclusive flags",
              nlong * 10 + nshort, 10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule